// File: doc/BRIEF.md
# Refresh Interval Scheduler with Postponement Credit

This block decides when a DRAM command path should issue a refresh. A free-running interval timer expires once per programmed period, measured in clock cycles. Each expiry adds one unit to a refresh debt. Each refresh acknowledged by the command path removes one unit. When the memory is idle and debt is owed, the block asks for a refresh. When the memory is busy, the block defers the request so the debt builds up, and the owed refreshes are drained back to back once traffic stops.

The debt has a ceiling. When it reaches the ceiling, an urgent flag rises and the request is raised even while the memory is busy, so the command path gives it priority over normal traffic. A thermal flag halves the interval, which doubles the refresh rate. The same logic serves an evenly spread schedule (acknowledge each request at once) and a deferred, grouped schedule (let debt build, then drain it).

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted, and directly after it, `ref_req` and `ref_urgent` are 0. Reset clears the debt and restarts the interval timer from zero.
- R2: With `temp_hot` low, the interval expires every max(`cfg_base_interval`, 1) cycles. With the memory idle, `ref_req` first rises at the clock edge numbered `cfg_base_interval` after reset release.
- R3: With `temp_hot` high, the period is max(floor(`cfg_base_interval`/2), 1) cycles.
- R4: Each expiry raises the debt by one. Each cycle with `ref_ack` high and a non-zero debt lowers it by one. `ref_ack` has no effect while the debt is zero.
- R5: The debt limit is `cfg_max_debt`, or 8 when `cfg_max_debt` is 0. An expiry that arrives while the debt is at or above the limit is dropped.
- R6: `ref_urgent` is 1 exactly when the debt is at or above the limit.
- R7: While `mem_busy` is 0, `ref_req` is 1 exactly when the debt is non-zero, so postponed refreshes drain on consecutive acknowledges.
- R8: While `mem_busy` is 1, `ref_req` is 1 only when `ref_urgent` is 1.
- R9: An expiry and an accepted acknowledge in the same cycle leave the debt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_busy | input | 1 | Memory is serving normal traffic |
| temp_hot | input | 1 | High-temperature flag; halves the interval |
| ref_ack | input | 1 | One refresh issued this cycle |
| cfg_base_interval | input | CNT_W | Base interval in cycles |
| cfg_max_debt | input | DEBT_W | Debt ceiling; 0 selects the default of 8 |
| ref_req | output | 1 | Refresh requested |
| ref_urgent | output | 1 | Debt is at its ceiling; refresh overrides traffic |

## Verification
The hardest state to reach is a saturated debt, where further expiries must be dropped. The ports can only reveal this indirectly, by counting how many acknowledges it takes to clear the request.

The bench keeps the memory busy for several intervals past the ceiling. It then stretches the interval so that no new expiry can arrive, and counts acknowledges until `ref_req` falls. A period of one cycle, with the acknowledge held high, produces an expiry and an acknowledge in every cycle, which exercises the case where both happen together.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  // Effective timer period in cycles; never below one.
  function automatic int unsigned eff_period(int unsigned base, logic hot);
    int unsigned p;
    p = hot ? (base >> 1) : base;
    return (p == 0) ? 1 : p;
  endfunction

  // Debt ceiling; a zero setting selects the default.
  function automatic int unsigned eff_limit(int unsigned cfg, int unsigned dflt);
    return (cfg == 0) ? dflt : cfg;
  endfunction

endpackage

// File: rtl/refsched_interval.sv
module refsched_interval #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] base,
  input  logic             hot,
  output logic             expire
);
  logic [CNT_W-1:0] elapsed_q;
  logic [CNT_W-1:0] period;
  logic [CNT_W:0]   next_cnt;

  assign period   = CNT_W'(refsched_pkg::eff_period(32'(base), hot));
  assign next_cnt = {1'b0, elapsed_q} + (CNT_W+1)'(1);
  // ">=" keeps a shortened period (hot set mid-interval) from overrunning
  assign expire   = next_cnt >= {1'b0, period};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      elapsed_q <= '0;
    else if (expire) elapsed_q <= '0;
    else             elapsed_q <= next_cnt[CNT_W-1:0];
  end
endmodule

// File: rtl/refsched_debt.sv
module refsched_debt #(
  parameter int DEBT_W   = 4,
  parameter int DEF_MAX  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              ack,
  input  logic [DEBT_W-1:0] cfg_max,
  output logic [DEBT_W-1:0] debt,
  output logic [DEBT_W-1:0] limit,
  output logic              ack_take
);
  logic [DEBT_W-1:0] debt_q, debt_d;

  assign limit    = DEBT_W'(refsched_pkg::eff_limit(32'(cfg_max), DEF_MAX));
  assign ack_take = ack && (debt_q != '0);

  always_comb begin
    debt_d = debt_q;
    unique case ({expire, ack_take})
      2'b10:   if (debt_q < limit) debt_d = debt_q + DEBT_W'(1);
      2'b01:   debt_d = debt_q - DEBT_W'(1);
      default: debt_d = debt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) debt_q <= '0;
    else        debt_q <= debt_d;
  end

  assign debt = debt_q;
endmodule

// File: rtl/refsched_req.sv
module refsched_req #(
  parameter int DEBT_W = 4
) (
  input  logic [DEBT_W-1:0] debt,
  input  logic [DEBT_W-1:0] limit,
  input  logic              busy,
  output logic              req,
  output logic              urgent
);
  assign urgent = debt >= limit;
  assign req    = (debt != '0) && (!busy || urgent);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int CNT_W   = 16,
  parameter int DEBT_W  = 4,
  parameter int DEF_MAX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_busy,
  input  logic              temp_hot,
  input  logic              ref_ack,
  input  logic [CNT_W-1:0]  cfg_base_interval,
  input  logic [DEBT_W-1:0] cfg_max_debt,
  output logic              ref_req,
  output logic              ref_urgent
);
  logic              tick_w;
  logic [DEBT_W-1:0] debt_w;
  logic [DEBT_W-1:0] limit_w;
  logic              take_w;

  refsched_interval #(.CNT_W(CNT_W)) u_intv (
    .clk(clk), .rst_n(rst_n), .base(cfg_base_interval), .hot(temp_hot),
    .expire(tick_w));

  refsched_debt #(.DEBT_W(DEBT_W), .DEF_MAX(DEF_MAX)) u_debt (
    .clk(clk), .rst_n(rst_n), .expire(tick_w), .ack(ref_ack),
    .cfg_max(cfg_max_debt), .debt(debt_w), .limit(limit_w), .ack_take(take_w));

  refsched_req #(.DEBT_W(DEBT_W)) u_req (
    .debt(debt_w), .limit(limit_w), .busy(mem_busy),
    .req(ref_req), .urgent(ref_urgent));
endmodule

// File: rtl/refsched_chk.sv
module refsched_chk #(
  parameter int DEBT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_busy,
  input logic              ref_ack,
  input logic              ref_req,
  input logic              ref_urgent,
  input logic              expire,
  input logic              take,
  input logic [DEBT_W-1:0] debt,
  input logic [DEBT_W-1:0] limit
);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_busy && ref_req) |-> ref_urgent);

  // R6
  urgent_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent |-> ref_req);

  // R4
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (debt > $past(debt)) |-> $past(expire));

  // R5
  cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (debt == $past(debt) + DEBT_W'(1)) |-> ($past(debt) < $past(limit)));

  // R4
  ack_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ref_ack) && !$past(expire) && $past(debt) != '0)
      |-> (debt == $past(debt) - DEBT_W'(1)));

  // R4
  zero_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(debt) == '0 && !$past(expire)) |-> (debt == '0));

  // R9
  both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(expire) && $past(take)) |-> (debt == $past(debt)));
endmodule

bind refresh_sched refsched_chk #(.DEBT_W(DEBT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_busy(mem_busy), .ref_ack(ref_ack),
  .ref_req(ref_req), .ref_urgent(ref_urgent), .expire(tick_w),
  .take(take_w), .debt(debt_w), .limit(limit_w));

// File: tb/test_refresh_sched.sv
module test_refresh_sched;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        mem_busy = 0, temp_hot = 0, ref_ack = 0;
  logic [15:0] cfg_base_interval = 16'd12;
  logic [3:0]  cfg_max_debt = 4'd0;
  logic        ref_req, ref_urgent;

  int checks = 0, fails = 0, cyc = 0;
  int m_el = 0, m_debt = 0;

  refresh_sched i_refresh_sched (
    .clk(clk), .rst_n(rst_n), .mem_busy(mem_busy), .temp_hot(temp_hot),
    .ref_ack(ref_ack), .cfg_base_interval(cfg_base_interval),
    .cfg_max_debt(cfg_max_debt), .ref_req(ref_req), .ref_urgent(ref_urgent));

  always #5 clk = ~clk;

  function automatic int lim_of();
    return (cfg_max_debt == 0) ? 8 : int'(cfg_max_debt);
  endfunction

  // behavioural reference, updated on the same edge as the design
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_el = 0; m_debt = 0;
    end else begin
      int per;
      bit ex, acc;
      per = temp_hot ? int'(cfg_base_interval) / 2 : int'(cfg_base_interval);
      if (per < 1) per = 1;
      ex  = (m_el + 1 >= per);
      m_el = ex ? 0 : m_el + 1;
      acc = ref_ack && (m_debt > 0);
      if (ex && !acc) begin
        if (m_debt < lim_of()) m_debt++;
      end else if (acc && !ex) m_debt--;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic er, eu;
    eu = rst_n && (m_debt >= lim_of());
    er = rst_n && (m_debt > 0) && (!mem_busy || eu);
    chk(ref_urgent, eu, "R6 urgent vs model");
    chk(ref_req, er, "R4 R7 R8 R9 request vs model");
  end

  task automatic do_reset(input int base, input int mx, input logic hot,
                          input logic busy, input logic ack);
    @(negedge clk); #1;
    rst_n = 0;
    cfg_base_interval = 16'(base); cfg_max_debt = 4'(mx);
    temp_hot = hot; mem_busy = busy; ref_ack = ack;
    @(negedge clk); #1;
    chk(ref_req, 1'b0, "R1 req in reset");
    chk(ref_urgent, 1'b0, "R1 urgent in reset");
    @(negedge clk); #1;
    rst_n = 1;
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!ref_req && n < 5000);
    #1;
  endtask

  task automatic ack_pulse();
    ref_ack = 1;
    @(negedge clk); #1;
    ref_ack = 0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    // R1, R2: normal period
    do_reset(12, 0, 1'b0, 1'b0, 1'b0);
    chk(ref_req, 1'b0, "R1 req after reset");
    wait_rise(n);
    chk(n == 12, 1'b1, "R2 first request after 12 edges");
    ack_pulse();
    chk(ref_req, 1'b0, "R7 req drops after ack");

    // R3: hot halves the period
    do_reset(12, 0, 1'b1, 1'b0, 1'b0);
    wait_rise(n);
    chk(n == 6, 1'b1, "R3 hot request after 6 edges");

    // R5 R6 R8: saturation while busy
    do_reset(40, 2, 1'b0, 1'b1, 1'b0);
    repeat (300) @(negedge clk);
    #1;
    chk(ref_urgent, 1'b1, "R6 urgent at ceiling");
    chk(ref_req, 1'b1, "R8 urgent request while busy");
    cfg_base_interval = 16'd1000;
    ack_pulse();
    chk(ref_urgent, 1'b0, "R6 urgent clears below ceiling");
    chk(ref_req, 1'b0, "R8 request held off while busy");
    mem_busy = 0; #1;
    chk(ref_req, 1'b1, "R7 idle drains debt");
    @(negedge clk); #1;
    ack_pulse();
    chk(ref_req, 1'b0, "R5 only two refreshes were owed");
    ack_pulse();
    chk(ref_req, 1'b0, "R4 ack at zero debt ignored");
    chk(ref_urgent, 1'b0, "R4 no underflow to urgent");

    // R9: expiry and ack together every cycle
    do_reset(1, 0, 1'b0, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    #1;
    chk(ref_req, 1'b1, "R9 debt held at one");
    chk(ref_urgent, 1'b0, "R9 no growth with simultaneous ack");
    ref_ack = 0;
    repeat (10) @(negedge clk);
    #1;
    chk(ref_urgent, 1'b1, "R5 default ceiling of 8 reached");

    // R2: base of zero behaves as one
    do_reset(0, 3, 1'b0, 1'b0, 1'b0);
    wait_rise(n);
    chk(n == 1, 1'b1, "R2 zero base acts as one cycle");

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule